// File: doc/BRIEF.md
# I2C Bus Master with Programmable Bit Divider

This block drives a two-wire I2C bus as its only master. It uses 7-bit addressing. A command port accepts one operation at a time: start, write byte, read byte or stop. Each operation reports its completion with a one-cycle response. The response carries the byte seen on the bus and a flag that is set when the slave did not acknowledge. Both bus wires are open-drain. Each is driven by an output enable that pulls the wire low when set, and each is read back through its own input.

Every bus bit takes one SCL period of M×(N+1) system clocks. N is a 7-bit divider setting. M is 8 when a low-speed flag is set and 6 otherwise. Each period is split into quarters. The master changes SDA only in the first half of the period, while SCL is low. It releases SCL at the half-way point and samples SDA three quarters of the way through. A slave can stretch the clock by holding SCL low after the master has released it. The divider then stops counting until SCL reads high.

Combined messages are built by sending a start while the bus is still held, which gives a repeated start. If the slave does not acknowledge the address or a written byte, the master ends the transfer with a stop on its own and raises a sticky error.

Top module: `i2c_host_ctl`

## Requirements
- R1: After reset, both open-drain enables are low (bus released), `cmd_ready` is 1, and `bus_busy` and `err_flag` are 0.
- R2: A start command (`cmd_op`=0) makes SDA fall while SCL is high, then pulls SCL low and sets `bus_busy`. Accepting it clears `err_flag`.
- R3: A write command (`cmd_op`=1) shifts `cmd_wdata` onto SDA most significant bit first, one bit per SCL period. It then releases SDA for a ninth bit and samples that bit as the acknowledge (low = ACK). An acknowledged write responds with `rsp_ack_err`=0.
- R4: A read command (`cmd_op`=2) samples eight bits most significant bit first and returns them on `rsp_rdata`. In the ninth bit the master pulls SDA low (ACK) when `cmd_nack_last`=0, and leaves SDA released (NACK) when `cmd_nack_last`=1.
- R5: A stop command (`cmd_op`=3) makes SDA rise while SCL is high, leaves both wires released and clears `bus_busy`. A stop issued while the bus is not held completes without any bus activity.
- R6: A start command issued while `bus_busy` is 1 produces a repeated start, with no stop condition in between.
- R7: With the bus free running, consecutive SCL rising edges inside a byte are M×(N+1) clocks apart. M=6 when `cfg_slow`=0 and M=8 when `cfg_slow`=1.
- R8: A divider setting of N=0 is treated as N=1.
- R9: While a slave holds SCL low after the master has released it, the master's bit timing waits. Each SCL period grows by the hold time and the data still transfers intact.
- R10: A NACK on a written byte (address or data) makes the master issue a stop by itself. The write then responds with `rsp_ack_err`=1, and `err_flag` is set and stays set until the next start command is accepted.
- R11: Outside start and stop conditions, the master changes its SDA enable only while it holds SCL low.
- R12: A command is taken only when `cmd_ready` is 1. Each command produces exactly one `rsp_valid` pulse, which occurs while `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_div_n | input | 7 | Divider setting N (0 behaves as 1) |
| cfg_slow | input | 1 | Selects M=8 when 1, M=6 when 0 |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_wdata | input | 8 | Byte to write |
| cmd_nack_last | input | 1 | Read: answer with NACK instead of ACK |
| cmd_ready | output | 1 | Block idle, command can be accepted |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte seen on the bus during the last read or write |
| rsp_ack_err | output | 1 | Slave did not acknowledge the written byte |
| err_flag | output | 1 | Sticky NACK error, cleared by the next start |
| bus_busy | output | 1 | Bus held between start and stop |
| scl_i | input | 1 | SCL wire level |
| scl_oe | output | 1 | Pull SCL low |
| sda_i | input | 1 | SDA wire level |
| sda_oe | output | 1 | Pull SDA low |

## Verification
Two events can land in the same cycle. One is the slave's clock hold. The other is the divider reaching the high half of the bit, where the sample point is gated. The bench forces this by having its slave model hold SCL low for a fixed number of clocks from the very edge on which the master releases it, so the stall begins on the first count after the release event. The test passes only if the measured rise-to-rise spacing grows by the hold time, and the scoreboard still matches every byte and acknowledge bit.

A second collision is a slave NACK followed by the stop the master issues on its own. In that case the error flag and the end of `bus_busy` must arrive together on the same edge. The bench checks both after the response.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_IDX_W = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } i2c_op_e;

  typedef enum logic [2:0] {
    SL_IDLE,
    SL_START,
    SL_BIT,
    SL_ACK,
    SL_STOP
  } slot_e;

  // Quarter-phase events inside one SCL period
  typedef struct packed {
    logic drive;   // SCL low half: update SDA
    logic rise;    // release SCL
    logic sample;  // SCL high: read SDA
    logic last;    // end of period
  } phase_ev_t;
endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer
  import i2c_host_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div_n,
  input  logic             slow,
  input  logic             scl_seen,
  input  logic             scl_released,
  output phase_ev_t        ev
);
  localparam int CW = DIV_W + 4;

  logic [DIV_W-1:0] n_eff;
  logic [CW-1:0]    nplus, period, q1, q2, q3, last_cnt, cnt;
  logic             stall;

  assign n_eff    = (div_n == '0) ? DIV_W'(1) : div_n;
  assign nplus    = CW'(n_eff) + CW'(1);
  assign period   = slow ? (nplus << 3) : ((nplus << 2) + (nplus << 1));
  assign q1       = period >> 2;
  assign q2       = period >> 1;
  assign q3       = q1 + q2;
  assign last_cnt = period - CW'(1);

  // slave holds SCL low after release: freeze the bit timing
  assign stall = scl_released && !scl_seen && (cnt > q2);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (!stall) begin
      cnt <= (cnt == last_cnt) ? '0 : cnt + CW'(1);
    end
  end

  assign ev.drive  = run && !stall && (cnt == q1);
  assign ev.rise   = run && !stall && (cnt == q2);
  assign ev.sample = run && !stall && (cnt == q3);
  assign ev.last   = run && !stall && (cnt == last_cnt);
endmodule

// File: rtl/i2c_host_seq.sv
module i2c_host_seq
  import i2c_host_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic              cmd_nack,
  input  phase_ev_t         ev,
  input  logic              sda_seen,
  output logic              cmd_ready,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              rsp_nack,
  output logic              err_flag,
  output logic              bus_busy,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              run,
  output logic              slot_edge
);
  slot_e                slot;
  i2c_op_e              op;
  logic [BYTE_W-1:0]    shreg;
  logic [BIT_IDX_W-1:0] bit_left;
  logic                 rd_mode, nack_q, nacked;

  assign op        = i2c_op_e'(cmd_op);
  assign cmd_ready = (slot == SL_IDLE);
  assign run       = (slot != SL_IDLE);
  assign slot_edge = (slot == SL_START) || (slot == SL_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot      <= SL_IDLE;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
      shreg     <= '0;
      bit_left  <= '0;
      rd_mode   <= 1'b0;
      nack_q    <= 1'b0;
      nacked    <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_nack  <= 1'b0;
      err_flag  <= 1'b0;
      bus_busy  <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (slot)
        SL_IDLE: if (cmd_valid) begin
          nacked   <= 1'b0;
          rd_mode  <= (op == OP_READ);
          nack_q   <= cmd_nack;
          shreg    <= cmd_wdata;
          bit_left <= BIT_IDX_W'(BYTE_W - 1);
          case (op)
            OP_START: begin
              slot     <= SL_START;
              err_flag <= 1'b0;
            end
            OP_WRITE, OP_READ: slot <= SL_BIT;
            default: begin
              if (bus_busy) begin
                slot <= SL_STOP;
              end else begin
                rsp_valid <= 1'b1;
                rsp_nack  <= 1'b0;
              end
            end
          endcase
        end
        SL_START: begin
          if (ev.drive)  sda_oe <= 1'b0;
          if (ev.rise)   scl_oe <= 1'b0;
          if (ev.sample) sda_oe <= 1'b1;
          if (ev.last) begin
            scl_oe    <= 1'b1;
            slot      <= SL_IDLE;
            bus_busy  <= 1'b1;
            rsp_valid <= 1'b1;
            rsp_nack  <= 1'b0;
          end
        end
        SL_BIT: begin
          if (ev.drive)  sda_oe <= rd_mode ? 1'b0 : ~shreg[BYTE_W-1];
          if (ev.rise)   scl_oe <= 1'b0;
          if (ev.sample) shreg  <= {shreg[BYTE_W-2:0], sda_seen};
          if (ev.last) begin
            scl_oe <= 1'b1;
            if (bit_left == '0) slot <= SL_ACK;
            else bit_left <= bit_left - BIT_IDX_W'(1);
          end
        end
        SL_ACK: begin
          if (ev.drive)  sda_oe <= rd_mode ? ~nack_q : 1'b0;
          if (ev.rise)   scl_oe <= 1'b0;
          if (ev.sample) nacked <= !rd_mode && sda_seen;
          if (ev.last) begin
            scl_oe <= 1'b1;
            if (nacked) begin
              slot <= SL_STOP;
            end else begin
              slot      <= SL_IDLE;
              rsp_valid <= 1'b1;
              rsp_rdata <= shreg;
              rsp_nack  <= 1'b0;
            end
          end
        end
        SL_STOP: begin
          if (ev.drive)  sda_oe <= 1'b1;
          if (ev.rise)   scl_oe <= 1'b0;
          if (ev.sample) sda_oe <= 1'b0;
          if (ev.last) begin
            slot      <= SL_IDLE;
            bus_busy  <= 1'b0;
            rsp_valid <= 1'b1;
            rsp_rdata <= shreg;
            rsp_nack  <= nacked;
            if (nacked) err_flag <= 1'b1;
          end
        end
        default: slot <= SL_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_host_ctl.sv
module i2c_host_ctl
  import i2c_host_pkg::*;
#(
  parameter int DIV_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div_n,
  input  logic              cfg_slow,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [BYTE_W-1:0] cmd_wdata,
  input  logic              cmd_nack_last,
  output logic              cmd_ready,
  output logic              rsp_valid,
  output logic [BYTE_W-1:0] rsp_rdata,
  output logic              rsp_ack_err,
  output logic              err_flag,
  output logic              bus_busy,
  input  logic              scl_i,
  output logic              scl_oe,
  input  logic              sda_i,
  output logic              sda_oe
);
  phase_ev_t ev;
  logic      run;
  logic      slot_edge;

  i2c_phase_timer #(.DIV_W(DIV_W)) u_timer (
    .clk          (clk),
    .rst          (rst),
    .run          (run),
    .div_n        (cfg_div_n),
    .slow         (cfg_slow),
    .scl_seen     (scl_i),
    .scl_released (!scl_oe),
    .ev           (ev)
  );

  i2c_host_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_wdata (cmd_wdata),
    .cmd_nack  (cmd_nack_last),
    .ev        (ev),
    .sda_seen  (sda_i),
    .cmd_ready (cmd_ready),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_nack  (rsp_ack_err),
    .err_flag  (err_flag),
    .bus_busy  (bus_busy),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .run       (run),
    .slot_edge (slot_edge)
  );
endmodule

// File: rtl/i2c_host_chk.sv
module i2c_host_chk (
  input logic clk,
  input logic rst,
  input logic scl_oe,
  input logic sda_oe,
  input logic scl_i,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic bus_busy,
  input logic err_flag,
  input logic slot_edge
);
  AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) && !$past(scl_oe) |-> $past(slot_edge)); // R11

  AST_STRETCH_WAIT: assert property (@(posedge clk) disable iff (rst)
    !scl_oe && !scl_i && !cmd_ready |=> !scl_oe); // R9

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    cmd_ready && !bus_busy |-> !scl_oe && !sda_oe); // R5

  AST_ERR_WITH_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> !bus_busy && rsp_valid); // R10

  AST_RSP_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> cmd_ready); // R12
endmodule

bind i2c_host_ctl i2c_host_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .scl_i     (scl_i),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .bus_busy  (bus_busy),
  .err_flag  (err_flag),
  .slot_edge (slot_edge)
);

// File: tb/test_i2c_host_ctl.sv
module test_i2c_host_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] cfg_div_n = 7'd3;
  logic       cfg_slow = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_wdata = 8'h00;
  logic       cmd_nack_last = 1'b0;
  logic       cmd_ready, rsp_valid, rsp_ack_err, err_flag, bus_busy;
  logic [7:0] rsp_rdata;
  logic       scl_oe, sda_oe;
  wire        scl_bus, sda_bus;

  // slave model state
  logic       slv_drive = 1'b0;
  int         stretch_k = 0;
  int         stretch_left = 0;
  logic       p_scl = 1'b1, p_sda = 1'b1;
  int         bitn = 0;
  logic       addr_ph = 1'b0, is_rd = 1'b0;
  logic [7:0] sh = 8'h00;
  logic [7:0] rd_bytes [4];
  int         rd_idx = 0;
  int         cyc = 0, last_rise = 0, meas = 0;

  int total = 0, bad = 0;
  logic done = 1'b0;
  logic [17:0] exp_q [$];

  localparam logic [6:0] SLV = 7'h50;
  localparam logic [1:0] EV_S = 2'd1, EV_P = 2'd2, EV_B = 2'd3;

  assign scl_bus = ~(scl_oe | (stretch_left != 0));
  assign sda_bus = ~(sda_oe | slv_drive);

  i2c_host_ctl i_i2c_host_ctl (
    .clk(clk), .rst(rst), .cfg_div_n(cfg_div_n), .cfg_slow(cfg_slow),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
    .cmd_nack_last(cmd_nack_last), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_ack_err(rsp_ack_err), .err_flag(err_flag),
    .bus_busy(bus_busy), .scl_i(scl_bus), .scl_oe(scl_oe), .sda_i(sda_bus),
    .sda_oe(sda_oe)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [17:0] mk(logic [1:0] t, logic [7:0] b, logic a);
    return {t, 7'd0, a, b};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard compare: R2 R3 R4 R5 R6 R11 (any stray START/STOP shows here)
  task automatic sb_pop(logic [17:0] got);
    if (exp_q.size() == 0) begin
      check(1'b0, "R11", "unexpected bus event", int'(got), 0);
    end else begin
      logic [17:0] e;
      e = exp_q.pop_front();
      check(got == e, "R3", "bus event", int'(got), int'(e));
    end
  endtask

  // monitor + slave model, sampled away from the active edge
  always @(negedge clk) begin
    logic cs, cd;
    cs = scl_bus;
    cd = sda_bus;
    if (!rst) begin
      if (p_scl && cs && p_sda && !cd) begin
        sb_pop(mk(EV_S, 8'h00, 1'b0));
        bitn = 0; addr_ph = 1'b1; is_rd = 1'b0; slv_drive = 1'b0;
      end else if (p_scl && cs && !p_sda && cd) begin
        sb_pop(mk(EV_P, 8'h00, 1'b0));
        addr_ph = 1'b0; is_rd = 1'b0; slv_drive = 1'b0;
      end else if (!p_scl && cs) begin
        if (bitn == 2) meas = cyc - last_rise;
        last_rise = cyc;
        if (bitn < 8) begin
          sh = {sh[6:0], cd};
          bitn++;
        end else begin
          sb_pop(mk(EV_B, sh, cd));
          bitn = 0;
          if (addr_ph) begin
            addr_ph = 1'b0;
            is_rd = sh[0] && !cd;
          end else if (is_rd) begin
            rd_idx++;
            if (cd) is_rd = 1'b0;
          end
        end
      end else if (p_scl && !cs) begin
        if (bitn == 8)
          slv_drive = !is_rd && ((addr_ph && sh[7:1] == SLV) || (!addr_ph && sh != 8'hEE));
        else
          slv_drive = is_rd && !rd_bytes[rd_idx % 4][7 - bitn];
      end
    end
    p_scl = cs;
    p_sda = cd;
    if (scl_oe) stretch_left = stretch_k;
    else if (stretch_left != 0) stretch_left--;
  end

  task automatic issue(input logic [1:0] op, input logic [7:0] wd, input logic nk,
                       output logic [7:0] rd, output logic ne);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = wd; cmd_nack_last = nk;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    ne = rsp_ack_err;
    check(cmd_ready == 1'b1, "R12", "ready during response", int'(cmd_ready), 1);
  endtask

  task automatic do_start();
    logic [7:0] r; logic n;
    exp_q.push_back(mk(EV_S, 8'h00, 1'b0));
    issue(2'd0, 8'h00, 1'b0, r, n);
    check(bus_busy == 1'b1, "R2", "busy after start", int'(bus_busy), 1);
    check(err_flag == 1'b0, "R10", "error cleared by start", int'(err_flag), 0);
  endtask

  task automatic do_write(input logic [7:0] b, input logic exp_nack);
    logic [7:0] r; logic n;
    exp_q.push_back(mk(EV_B, b, exp_nack));
    if (exp_nack) exp_q.push_back(mk(EV_P, 8'h00, 1'b0));
    issue(2'd1, b, 1'b0, r, n);
    check(n == exp_nack, "R3", "write ack status", int'(n), int'(exp_nack));
    if (exp_nack) begin
      check(err_flag == 1'b1, "R10", "sticky error", int'(err_flag), 1);
      check(bus_busy == 1'b0, "R10", "auto stop freed bus", int'(bus_busy), 0);
    end
  endtask

  task automatic do_read(input logic [7:0] expb, input logic nk);
    logic [7:0] r; logic n;
    exp_q.push_back(mk(EV_B, expb, nk));
    issue(2'd2, 8'h00, nk, r, n);
    check(r == expb, "R4", "read data", int'(r), int'(expb));
  endtask

  task automatic do_stop(input logic held);
    logic [7:0] r; logic n;
    if (held) exp_q.push_back(mk(EV_P, 8'h00, 1'b0));
    issue(2'd3, 8'h00, 1'b0, r, n);
    repeat (3) @(negedge clk);
    check(bus_busy == 1'b0, "R5", "busy after stop", int'(bus_busy), 0);
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R5", "wires released",
          int'({scl_oe, sda_oe}), 0);
  endtask

  task automatic period_run(input logic [6:0] n, input logic slow, input int expect_p,
                            input string req);
    cfg_div_n = n; cfg_slow = slow;
    do_start();
    do_write(8'hA0, 1'b0);
    do_stop(1'b1);
    check(meas == expect_p, req, "SCL period", meas, expect_p);
  endtask

  initial begin
    rd_bytes[0] = 8'h96; rd_bytes[1] = 8'h4B; rd_bytes[2] = 8'h00; rd_bytes[3] = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "enables after reset", int'({scl_oe, sda_oe}), 0);
    check(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
    check(bus_busy == 1'b0 && err_flag == 1'b0, "R1", "status after reset",
          int'({bus_busy, err_flag}), 0);

    // R5: stop while not holding the bus causes no bus event
    do_stop(1'b0);

    // R2 R3 R5: plain write message
    do_start();
    do_write(8'hA0, 1'b0);
    do_write(8'h3C, 1'b0);
    do_write(8'h81, 1'b0);
    do_stop(1'b1);
    check(meas == 24, "R7", "period M=6 N=3", meas, 24);

    // R6 R4: combined message with repeated start and reads
    do_start();
    do_write(8'hA0, 1'b0);
    do_write(8'h05, 1'b0);
    do_start();
    do_write(8'hA1, 1'b0);
    do_read(8'h96, 1'b0);
    do_read(8'h4B, 1'b1);
    do_stop(1'b1);
    check(exp_q.size() == 0, "R6", "events pending after combined", exp_q.size(), 0);

    // R10: address NACK, then data NACK after error cleared
    do_start();
    do_write(8'hB4, 1'b1);
    do_start();
    do_write(8'hA0, 1'b0);
    do_write(8'hEE, 1'b1);

    // R7 R8: divider variants
    period_run(7'd3, 1'b1, 32, "R7");
    period_run(7'd0, 1'b0, 12, "R8");

    // R9: slave stretches every high phase
    cfg_div_n = 7'd3; cfg_slow = 1'b0;
    stretch_k = 20;
    do_start();
    do_write(8'hA0, 1'b0);
    do_write(8'h5A, 1'b0);
    do_stop(1'b1);
    stretch_k = 0;
    check(meas >= 41 && meas <= 45, "R9", "stretched period", meas, 43);

    check(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog expired: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule